// File: doc/BRIEF.md
# Pipelined Length-8 Successive-Cancellation Polar Decoder

This block decodes length-8 polar codewords by successive cancellation with min-sum arithmetic. It accepts one vector of eight channel log-likelihood ratios and one 8-bit information mask per clock. It returns one fully decoded 8-bit word per clock, two cycles after the input was accepted. The decoder is built from two identical length-4 combinational decoders. The first works on check-node combinations of the incoming LLR pairs. The second works on variable-node combinations that depend on the first half's re-encoded decisions.

A single register stage separates the two half-decoders. It captures the raw LLRs of a codeword, the partial sums derived from its first four decisions, those decisions themselves and the upper half of its information mask. As a result the first half-decoder can take the next codeword in the very next cycle. The stored first-half decisions travel with the codeword, so the output word is realigned: all eight bits of every emitted word belong to the same codeword. Because the mask enters with each codeword, the code rate and the frozen set can change from one word to the next.

Top module: `polar_pipe_dec8`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted codeword emerges, `out_valid` is 0 and `out_bits` is all zeros. Asserting `rst_n` low discards every codeword in flight.
- R2: `out_valid` is 1 in the cycle that follows exactly two rising edges after a cycle with `in_valid` high, and 0 otherwise. Idle input cycles pass through as idle output cycles.
- R3: The LLR for position i sits in `in_llr[i*LLR_W +: LLR_W]` as two's complement. Output bits `out_bits[3:0]` equal a length-4 successive-cancellation decode of c(i) = f(l(2i), l(2i+1)) for i = 0..3, using mask bits `in_info[3:0]`. Here f(a,b) has magnitude min(|a|,|b|), clamped to 2^(LLR_W-1)-1, and is negative exactly when one of a and b is negative.
- R4: The partial sums used for the second half are p0 = u0^u1^u2^u3, p1 = u1^u3, p2 = u2^u3 and p3 = u3, where u0..u3 are the first-half decisions.
- R5: `out_bits[7:4]` equal a length-4 decode of d(i) = g(l(2i), l(2i+1), p(i)) using `in_info[7:4]`. Here g(a,b,p) = b + a when p = 0 and b - a when p = 1, clamped to +/-(2^(LLR_W-1)-1).
- R6: The length-4 decode of inputs x0..x3 with mask m0..m3 works as follows. It takes e0 = f(x0,x1) and e1 = f(x2,x3), then decides u0 from f(e0,e1) and u1 from g(e0,e1,u0). It then takes h0 = g(x0,x1,u0^u1) and h1 = g(x2,x3,u1), and decides u2 from f(h0,h1) and u3 from g(h0,h1,u2). All intermediate values are clamped as in R3 and R5, including the extreme codes.
- R7: A decision bit is 1 only when its LLR is strictly negative and its mask bit is 1. Mask bit value 0 marks a frozen position, which always decodes to 0.
- R8: With valid inputs on consecutive cycles, every output word is the decode of one single input codeword. No word mixes halves of different codewords.
- R9: In a cycle with `out_valid` 0, `out_bits` keeps the last emitted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | A codeword is presented this cycle |
| in_llr | input | 8*LLR_W | Eight channel LLRs, position i at bits [i*LLR_W +: LLR_W], two's complement |
| in_info | input | 8 | Bit i = 1 marks position i as information, 0 as frozen |
| out_valid | output | 1 | `out_bits` carries a newly decoded word |
| out_bits | output | 8 | Decoded bits, bit i is decision u(i) |

## Verification
Errors in the check-node or variable-node arithmetic show up in the very next emitted word, as a wrong bit in the lower or upper nibble. Saturating inputs at both extreme codes expose clamping faults. A fault in the partial-sum encoder or in the stored LLRs corrupts only the upper nibble, two cycles after the input. A misaligned pipeline register mixes halves of neighbouring codewords, and streams of distinct back-to-back words expose that at once. Any slip in the valid pipeline shifts `out_valid` by a cycle relative to the input, and the held-word behaviour during bubbles reveals an enable fault on the first idle cycle.

// File: rtl/polar_pkg.sv
package polar_pkg;
  localparam int BLK_N  = 8;
  localparam int HALF_N = BLK_N / 2;

  // Length-4 polar transform used to form partial sums from first-half decisions
  function automatic logic [3:0] polar_xform4(input logic [3:0] u);
    logic [3:0] p;
    p[0] = u[0] ^ u[1] ^ u[2] ^ u[3];
    p[1] = u[1] ^ u[3];
    p[2] = u[2] ^ u[3];
    p[3] = u[3];
    return p;
  endfunction
endpackage

// File: rtl/polar_fnode.sv
// Min-sum check node with symmetric clamp (R3)
module polar_fnode #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] MAXM = W'((2 ** (W - 1)) - 1);

  logic [W-1:0] mag_a, mag_b, mag_m;

  always_comb begin
    mag_a = a[W-1] ? (~a + 1'b1) : a;
    mag_b = b[W-1] ? (~b + 1'b1) : b;
    mag_m = (mag_a < mag_b) ? mag_a : mag_b;
    if (mag_m > MAXM) mag_m = MAXM;
    y = (a[W-1] ^ b[W-1]) ? (~mag_m + 1'b1) : mag_m;
  end
endmodule

// File: rtl/polar_gnode.sv
// Variable node: b + a or b - a, clamped symmetrically (R5)
module polar_gnode #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         p,
  output logic [W-1:0] y
);
  localparam logic signed [W:0] POS = (W+1)'((2 ** (W - 1)) - 1);
  localparam logic signed [W:0] NEG = -POS;

  logic signed [W:0] ax, bx, sum;

  always_comb begin
    ax  = $signed({a[W-1], a});
    bx  = $signed({b[W-1], b});
    sum = p ? (bx - ax) : (bx + ax);
    if (sum > POS)      y = POS[W-1:0];
    else if (sum < NEG) y = NEG[W-1:0];
    else                y = sum[W-1:0];
  end
endmodule

// File: rtl/polar_dec4.sv
// Combinational length-4 successive-cancellation decoder (R6, R7)
module polar_dec4 #(
  parameter int W = 6
) (
  input  logic [4*W-1:0] llr,
  input  logic [3:0]     info,
  output logic [3:0]     bits
);
  logic [W-1:0] x0, x1, x2, x3;
  logic [W-1:0] e0, e1, r0, r1, h0, h1, r2, r3;
  logic         d0, d1, d2, d3;

  assign x0 = llr[0*W +: W];
  assign x1 = llr[1*W +: W];
  assign x2 = llr[2*W +: W];
  assign x3 = llr[3*W +: W];

  // first pair: check nodes, then decisions u0 and u1
  polar_fnode #(.W(W)) u_fe0 (.a(x0), .b(x1), .y(e0));
  polar_fnode #(.W(W)) u_fe1 (.a(x2), .b(x3), .y(e1));
  polar_fnode #(.W(W)) u_fr0 (.a(e0), .b(e1), .y(r0));
  assign d0 = r0[W-1] & info[0];
  polar_gnode #(.W(W)) u_gr1 (.a(e0), .b(e1), .p(d0), .y(r1));
  assign d1 = r1[W-1] & info[1];

  // second pair: variable nodes with local partial sums, then u2 and u3
  polar_gnode #(.W(W)) u_gh0 (.a(x0), .b(x1), .p(d0 ^ d1), .y(h0));
  polar_gnode #(.W(W)) u_gh1 (.a(x2), .b(x3), .p(d1), .y(h1));
  polar_fnode #(.W(W)) u_fr2 (.a(h0), .b(h1), .y(r2));
  assign d2 = r2[W-1] & info[2];
  polar_gnode #(.W(W)) u_gr3 (.a(h0), .b(h1), .p(d2), .y(r3));
  assign d3 = r3[W-1] & info[3];

  assign bits = {d3, d2, d1, d0};
endmodule

// File: rtl/polar_pipe_dec8.sv
module polar_pipe_dec8 #(
  parameter int LLR_W = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [polar_pkg::BLK_N*LLR_W-1:0]    in_llr,
  input  logic [polar_pkg::BLK_N-1:0]          in_info,
  output logic                                 out_valid,
  output logic [polar_pkg::BLK_N-1:0]          out_bits
);
  import polar_pkg::*;

  localparam int N    = BLK_N;
  localparam int HALF = HALF_N;
  localparam int VW   = N * LLR_W;
  localparam int HW   = HALF * LLR_W;

  // ---------------- first half (combinational from the inputs) ----------------
  logic [HW-1:0]   cn_vec;
  logic [HALF-1:0] lo_bits;
  logic [HALF-1:0] lo_psum;

  for (genvar i = 0; i < HALF; i++) begin : g_cn
    polar_fnode #(.W(LLR_W)) u_cn (
      .a (in_llr[(2*i)*LLR_W +: LLR_W]),
      .b (in_llr[(2*i+1)*LLR_W +: LLR_W]),
      .y (cn_vec[i*LLR_W +: LLR_W])
    );
  end

  polar_dec4 #(.W(LLR_W)) u_dec_lo (
    .llr  (cn_vec),
    .info (in_info[HALF-1:0]),
    .bits (lo_bits)
  );

  assign lo_psum = polar_xform4(lo_bits);

  // ---------------- pipeline cut: next state ----------------
  logic            st_vld_q, st_vld_d;
  logic [VW-1:0]   st_llr_q, st_llr_d;
  logic [HALF-1:0] st_psum_q, st_psum_d;
  logic [HALF-1:0] st_lo_q, st_lo_d;
  logic [HALF-1:0] st_info_q, st_info_d;
  logic            st_en;

  assign st_en = in_valid;

  always_comb begin
    st_vld_d  = in_valid;
    st_llr_d  = st_llr_q;
    st_psum_d = st_psum_q;
    st_lo_d   = st_lo_q;
    st_info_d = st_info_q;
    if (st_en) begin
      st_llr_d  = in_llr;
      st_psum_d = lo_psum;
      st_lo_d   = lo_bits;
      st_info_d = in_info[N-1:HALF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld_q  <= 1'b0;
      st_llr_q  <= '0;
      st_psum_q <= '0;
      st_lo_q   <= '0;
      st_info_q <= '0;
    end else begin
      st_vld_q  <= st_vld_d;
      st_llr_q  <= st_llr_d;
      st_psum_q <= st_psum_d;
      st_lo_q   <= st_lo_d;
      st_info_q <= st_info_d;
    end
  end

  // ---------------- second half (from stored codeword) ----------------
  logic [HW-1:0]   vn_vec;
  logic [HALF-1:0] hi_bits;

  for (genvar i = 0; i < HALF; i++) begin : g_vn
    polar_gnode #(.W(LLR_W)) u_vn (
      .a (st_llr_q[(2*i)*LLR_W +: LLR_W]),
      .b (st_llr_q[(2*i+1)*LLR_W +: LLR_W]),
      .p (st_psum_q[i]),
      .y (vn_vec[i*LLR_W +: LLR_W])
    );
  end

  polar_dec4 #(.W(LLR_W)) u_dec_hi (
    .llr  (vn_vec),
    .info (st_info_q),
    .bits (hi_bits)
  );

  // ---------------- output register: realigned word ----------------
  logic         ov_d;
  logic [N-1:0] ob_d;

  always_comb begin
    ov_d = st_vld_q;
    ob_d = out_bits;
    if (st_vld_q) ob_d = {hi_bits, st_lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      out_valid <= ov_d;
      out_bits  <= ob_d;
    end
  end
endmodule

// File: rtl/polar_pipe_dec8_chk.sv
module polar_pipe_dec8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_info,
  input logic       out_valid,
  input logic [7:0] out_bits
);
  logic       sh_v1, sh_v2;
  logic [7:0] sh_m1, sh_m2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v1 <= 1'b0;
      sh_v2 <= 1'b0;
      sh_m1 <= '0;
      sh_m2 <= '0;
    end else begin
      sh_v1 <= in_valid;
      sh_v2 <= sh_v1;
      if (in_valid) sh_m1 <= in_info;
      if (sh_v1)    sh_m2 <= sh_m1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_bits == 8'h00));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh_v2);

  assert_frozen_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bits & ~sh_m2) == 8'h00));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_bits));
endmodule

bind polar_pipe_dec8 polar_pipe_dec8_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_info   (in_info),
  .out_valid (out_valid),
  .out_bits  (out_bits)
);

// File: tb/tb_polar_pipe_dec8.sv
`timescale 1ns/1ps
module tb_polar_pipe_dec8;
  localparam int W    = 6;
  localparam int MAXM = (2 ** (W - 1)) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [8*W-1:0] in_llr = '0;
  logic [7:0]     in_info = '0;
  logic           out_valid;
  logic [7:0]     out_bits;

  int n_checks = 0;
  int n_errors = 0;

  logic       hv [0:1];
  logic [7:0] hw [0:1];
  logic [7:0] last_word;
  logic [15:0] lfsr = 16'hACE1;

  polar_pipe_dec8 #(.LLR_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
    .in_info(in_info), .out_valid(out_valid), .out_bits(out_bits)
  );

  always #10 clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  function automatic int clampm(int x);
    if (x > MAXM) return MAXM;
    if (x < -MAXM) return -MAXM;
    return x;
  endfunction

  function automatic int mf(int a, int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m = (ma < mb) ? ma : mb;
    if (m > MAXM) m = MAXM;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  function automatic int mg(int a, int b, bit p);
    return clampm(p ? (b - a) : (b + a));
  endfunction

  function automatic bit [3:0] mdec4(int x0, int x1, int x2, int x3, bit [3:0] m);
    int e0, e1, h0, h1;
    bit [3:0] u;
    e0 = mf(x0, x1);
    e1 = mf(x2, x3);
    u[0] = (mf(e0, e1) < 0) & m[0];
    u[1] = (mg(e0, e1, u[0]) < 0) & m[1];
    h0 = mg(x0, x1, u[0] ^ u[1]);
    h1 = mg(x2, x3, u[1]);
    u[2] = (mf(h0, h1) < 0) & m[2];
    u[3] = (mg(h0, h1, u[2]) < 0) & m[3];
    return u;
  endfunction

  function automatic bit [7:0] mdec8(logic [8*W-1:0] l, bit [7:0] m);
    int v [8];
    int c [4];
    bit [3:0] lo, hi, p;
    for (int i = 0; i < 8; i++) v[i] = int'($signed(l[i*W +: W]));
    for (int i = 0; i < 4; i++) c[i] = mf(v[2*i], v[2*i+1]);
    lo = mdec4(c[0], c[1], c[2], c[3], m[3:0]);
    p[0] = lo[0] ^ lo[1] ^ lo[2] ^ lo[3];
    p[1] = lo[1] ^ lo[3];
    p[2] = lo[2] ^ lo[3];
    p[3] = lo[3];
    for (int i = 0; i < 4; i++) c[i] = mg(v[2*i], v[2*i+1], p[i]);
    hi = mdec4(c[0], c[1], c[2], c[3], m[7:4]);
    return {hi, lo};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rnd_llr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[W-1:0];
  endfunction

  // one cycle: compare outputs to the input given two steps earlier, then drive
  task automatic step(input logic v, input logic [8*W-1:0] l, input logic [7:0] m,
                      input string tag);
    @(negedge clk);
    check(out_valid === hv[1], {tag, " R2 out_valid"}, int'(out_valid), int'(hv[1]));
    if (hv[1]) begin
      check(out_bits === hw[1], {tag, " word"}, int'(out_bits), int'(hw[1]));
      last_word = hw[1];
    end else begin
      check(out_bits === last_word, {tag, " R9 hold"}, int'(out_bits), int'(last_word));
    end
    hv[1] = hv[0];
    hw[1] = hw[0];
    hv[0] = v;
    hw[0] = v ? mdec8(l, m) : 8'h00;
    in_valid = v;
    in_llr   = l;
    in_info  = m;
  endtask

  task automatic flush(input string tag);
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, tag);
  endtask

  function automatic logic [8*W-1:0] rnd_vec();
    logic [8*W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*W +: W] = rnd_llr();
    return r;
  endfunction

  function automatic logic [8*W-1:0] const_vec(int val);
    logic [8*W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*W +: W] = W'(val);
    return r;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_bits === 8'h00, "R1 reset bits", int'(out_bits), 0);
    rst_n = 1'b1;
    hv[0] = 0; hv[1] = 0; hw[0] = 0; hw[1] = 0; last_word = 8'h00;
    flush("R1 after reset");
  endtask

  task automatic t_uniform();
    step(1'b1, const_vec(5), 8'hFF, "R7 positive all info");
    step(1'b1, const_vec(-5), 8'hFF, "R7 negative all info");
    step(1'b1, const_vec(-7), 8'h00, "R7 all frozen");
    step(1'b1, const_vec(0), 8'hFF, "R7 zero llr");
    flush("R7 drain");
  endtask

  task automatic t_mixed();
    logic [8*W-1:0] v;
    v = '0;
    v[0*W +: W] = W'(-3); v[1*W +: W] = W'(9);  v[2*W +: W] = W'(4);  v[3*W +: W] = W'(-12);
    v[4*W +: W] = W'(7);  v[5*W +: W] = W'(-2); v[6*W +: W] = W'(-8); v[7*W +: W] = W'(1);
    step(1'b1, v, 8'hE8, "R3 R5 mixed rate-half");
    step(1'b1, v, 8'hFF, "R4 mixed all info");
    step(1'b1, v, 8'h0F, "R3 lower only");
    step(1'b1, v, 8'hF0, "R5 upper only");
    flush("R4 drain");
  endtask

  task automatic t_stream();
    logic [7:0] masks [4] = '{8'hE8, 8'hFE, 8'h7F, 8'hAA};
    for (int k = 0; k < 40; k++)
      step(1'b1, rnd_vec(), masks[k % 4], "R8 R4 back-to-back");
    flush("R8 drain");
  endtask

  task automatic t_bubbles();
    step(1'b1, rnd_vec(), 8'hFF, "R2 bubble a");
    step(1'b0, rnd_vec(), 8'hFF, "R9 idle 1");
    step(1'b1, rnd_vec(), 8'hFF, "R2 bubble b");
    step(1'b0, rnd_vec(), 8'hFF, "R9 idle 2");
    step(1'b0, rnd_vec(), 8'hFF, "R9 idle 3");
    step(1'b1, rnd_vec(), 8'hF7, "R2 bubble c");
    step(1'b0, '0, 8'h00, "R9 idle 4");
    flush("R2 drain");
  endtask

  task automatic t_saturation();
    logic [8*W-1:0] v;
    step(1'b1, const_vec(-(MAXM + 1)), 8'hFF, "R6 most negative");
    step(1'b1, const_vec(MAXM), 8'hFF, "R6 most positive");
    for (int k = 0; k < 8; k++) begin
      v = '0;
      for (int i = 0; i < 8; i++)
        v[i*W +: W] = ((i + k) % 3 == 0) ? W'(-(MAXM + 1)) : W'(MAXM - i);
      step(1'b1, v, 8'hFF - 8'(k), "R6 clamp mix");
    end
    flush("R6 drain");
  endtask

  task automatic t_reset_mid();
    step(1'b1, rnd_vec(), 8'hFF, "R1 in flight a");
    step(1'b1, rnd_vec(), 8'hFF, "R1 in flight b");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check(out_valid === 1'b0, "R1 mid-run valid", int'(out_valid), 0);
    check(out_bits === 8'h00, "R1 mid-run bits", int'(out_bits), 0);
    @(negedge clk);
    rst_n = 1'b1;
    hv[0] = 0; hv[1] = 0; hw[0] = 0; hw[1] = 0; last_word = 8'h00;
    flush("R1 after mid reset");
  endtask

  initial begin
    #(200000 * 20);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    hv[0] = 0; hv[1] = 0; hw[0] = 0; hw[1] = 0; last_word = 8'h00;
    t_reset();
    t_uniform();
    t_mixed();
    t_stream();
    t_bubbles();
    t_saturation();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule